// File: doc/BRIEF.md
# Layer-Streamed Pattern Majority Matcher

This block recognises track-like patterns that are spread over six detector layers. Each layer delivers a stream of 16-bit hit words. A fixed lookup table is built into logic for each layer. It turns every word into the list of pattern numbers that contain that word in that layer. One word can name several patterns. The list is pushed one number per cycle into a small queue for that layer. While a list is being pushed, the layer stream stalls.

A vote unit drains all six queues. For each pattern it records which layers named it, as one bit per layer. Each layer ends an event with an end-of-event marker. Once the markers of all six layers have been taken, the vote unit walks the pattern numbers in ascending order. It offers on a valid/ready output every pattern that was named by at least a threshold number of distinct layers, then clears its records and pulses a done flag. Entries a layer delivers after its own marker stay queued for the following event. The threshold is a plain control register that resets to 5.

The input lanes are valid/ready. A word or marker is taken on a clock edge where `lane_valid` and `lane_ready` are both high. The block drops `lane_ready` while it pushes the numbers fired by the previous word. The output stream holds `hit_valid` and `hit_id` steady until `hit_ready` is seen high. A low `hit_ready` stalls the walk. The walk does not take new markers until the event is finished.

Top module: `pattern_vote_top`

## Requirements
- R1: The lookup fires patterns from word bits. For a word on layer L, bits [15:12] must equal L and bits [11:5] must be zero. Bits [4:0] form a base b, and s = L mod 3. If b < 32/2^s, the word fires the patterns b*2^s through b*2^s + 2^s - 1. Any other word fires nothing.
- R2: After a word that fires c patterns is taken, `lane_ready` of that lane is low for exactly c cycles. After a marker is taken, it is low for exactly 1 cycle. A word that fires nothing does not stall the lane.
- R3: Each lane queue holds 8 entries. An entry produced while the queue is full is discarded. When that happens, the lane's `lane_ovf` bit goes high and stays high until reset.
- R4: A pattern fired more than once by the same layer within an event counts as one layer.
- R5: After all six markers of an event, every pattern named by at least the threshold number of distinct layers is output exactly once, in ascending order. No other pattern is output. `evt_done` then pulses for one cycle, and `hit_valid` is low in that cycle.
- R6: The threshold resets to 5. A cycle with `thr_wr` high loads `thr_val` into it.
- R7: The vote records clear after each event, so no vote carries into the next event.
- R8: While `hit_valid` is high and `hit_ready` is low, `hit_valid` and `hit_id` hold on the next cycle.
- R9: After reset, every `lane_ready` is high, and `hit_valid`, `evt_done` and every `lane_ovf` bit are low.
- R10: Words a lane delivers after its own marker do not vote in the current event. They vote in the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_wr | input | 1 | Load the vote threshold |
| thr_val | input | 3 | Threshold value to load |
| lane_valid | input | 6 | Per-layer word or marker valid |
| lane_eoe | input | 6 | Per-layer marker flag (word ignored when set) |
| lane_word | input | 96 | Per-layer hit words, layer L in bits [16L+15:16L] |
| lane_ready | output | 6 | Per-layer ready |
| lane_ovf | output | 6 | Per-layer sticky queue overflow |
| hit_valid | output | 1 | Selected pattern valid |
| hit_ready | input | 1 | Output consumer ready |
| hit_id | output | 5 | Selected pattern number |
| evt_done | output | 1 | One-cycle pulse after an event's output walk |

## Verification
The assertions check several rules on every cycle. A lane stalls after a firing word or a marker, and does not stall after a silent word. The overflow flags never fall. The output holds under back-pressure. Output numbers rise within an event, and the done pulse never coincides with a valid output. Other behaviours only the bench scenarios can show: which patterns the lookup fires, vote counting with duplicates and threshold changes, the carry of early words into the next event, and the loss of a discarded entry. The bench shows these by comparing each event's output list with lists it computes from the word encoding.

// File: rtl/pvm_pkg.sv
package pvm_pkg;

  typedef enum logic [1:0] {
    MJ_COLLECT = 2'd0,
    MJ_EMIT    = 2'd1,
    MJ_DONE    = 2'd2
  } mj_state_e;

  // Fan-out exponent of a layer's lookup: 2**shift patterns share a word.
  function automatic int unsigned shift_of(input int unsigned layer);
    return layer % 3;
  endfunction

endpackage

// File: rtl/pvm_comparator.sv
module pvm_comparator #(
  parameter int unsigned LAYER    = 0,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned ID_W     = 5,
  parameter int unsigned NUM_PAT  = 32,
  parameter int unsigned MAX_FIRE = 4,
  localparam int unsigned CNT_W   = $clog2(MAX_FIRE + 1)
) (
  input  logic [WORD_W-1:0]                word_i,
  output logic [CNT_W-1:0]                 cnt_o,
  output logic [MAX_FIRE-1:0][ID_W-1:0]    ids_o
);

  localparam int unsigned SH    = pvm_pkg::shift_of(LAYER);
  localparam int unsigned FAN   = 1 << SH;
  localparam int unsigned BASES = NUM_PAT >> SH;

  logic            tag_ok;
  logic            pad_ok;
  logic            base_ok;
  logic [ID_W-1:0] base;

  always_comb begin
    tag_ok  = (word_i[WORD_W-1 -: 4] == 4'(LAYER));
    pad_ok  = (word_i[WORD_W-5:ID_W] == '0);
    base    = word_i[ID_W-1:0];
    base_ok = (32'(base) < BASES);
    cnt_o   = (tag_ok && pad_ok && base_ok) ? CNT_W'(FAN) : '0;
  end

  for (genvar j = 0; j < MAX_FIRE; j++) begin : g_slot
    if (j < FAN) begin : g_used
      assign ids_o[j] = ID_W'((32'(base) << SH) + 32'(j));
    end else begin : g_spare
      assign ids_o[j] = '0;
    end
  end

endmodule

// File: rtl/pvm_layer_ingest.sv
module pvm_layer_ingest #(
  parameter int unsigned ID_W     = 5,
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned MAX_FIRE = 4,
  localparam int unsigned CNT_W   = $clog2(MAX_FIRE + 1),
  localparam int unsigned IDX_W   = $clog2(MAX_FIRE),
  localparam int unsigned PTR_W   = $clog2(DEPTH),
  localparam int unsigned OCC_W   = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_eoe,
  output logic                          in_ready,
  input  logic [CNT_W-1:0]              fire_cnt,
  input  logic [MAX_FIRE-1:0][ID_W-1:0] fire_ids,
  input  logic                          pop_i,
  output logic [ID_W:0]                 head_o,
  output logic                          empty_o,
  output logic                          ovf_o
);

  logic [CNT_W-1:0]              pend_left;
  logic [IDX_W-1:0]              pend_idx;
  logic                          pend_eoe;
  logic [MAX_FIRE-1:0][ID_W-1:0] pend_ids;

  logic [ID_W:0]  mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [OCC_W-1:0] occ;

  logic          accept;
  logic          push;
  logic          full;
  logic          do_wr;
  logic          do_rd;
  logic [ID_W:0] push_entry;

  always_comb begin
    in_ready   = (pend_left == '0);
    accept     = in_valid && in_ready;
    push       = (pend_left != '0);
    full       = (occ == OCC_W'(DEPTH));
    empty_o    = (occ == '0);
    do_wr      = push && !full;
    do_rd      = pop_i && !empty_o;
    push_entry = pend_eoe ? {1'b1, {ID_W{1'b0}}} : {1'b0, pend_ids[pend_idx]};
    head_o     = mem[rd_ptr];
  end

  // Serializer: one fired number (or the marker) per cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_left <= '0;
      pend_idx  <= '0;
      pend_eoe  <= 1'b0;
      pend_ids  <= '0;
    end else if (accept) begin
      pend_eoe  <= in_eoe;
      pend_ids  <= fire_ids;
      pend_idx  <= '0;
      pend_left <= in_eoe ? CNT_W'(1) : fire_cnt;
    end else if (push) begin
      pend_left <= pend_left - CNT_W'(1);
      pend_idx  <= pend_idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (do_rd) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      case ({do_wr, do_rd})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
      if (push && full) ovf_o <= 1'b1;
    end
  end

endmodule

// File: rtl/pvm_majority.sv
module pvm_majority #(
  parameter int unsigned LAYERS  = 6,
  parameter int unsigned ID_W    = 5,
  parameter int unsigned NUM_PAT = 32,
  localparam int unsigned THR_W  = $clog2(LAYERS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LAYERS-1:0]             empty_i,
  input  logic [LAYERS-1:0][ID_W:0]     heads_i,
  output logic [LAYERS-1:0]             pop_o,
  input  logic [THR_W-1:0]              thr_i,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [ID_W-1:0]               out_id,
  output logic                          evt_done
);

  import pvm_pkg::*;

  mj_state_e                         state;
  logic [NUM_PAT-1:0][LAYERS-1:0]    hits;
  logic [LAYERS-1:0]                 seen;
  logic [ID_W-1:0]                   idx;
  logic                              match;
  logic                              advance;

  always_comb begin
    for (int l = 0; l < LAYERS; l++) begin
      pop_o[l] = (state == MJ_COLLECT) && !seen[l] && !empty_i[l];
    end
    match     = ($countones(hits[idx]) >= int'(thr_i));
    out_valid = (state == MJ_EMIT) && match;
    out_id    = idx;
    advance   = (state == MJ_EMIT) && (!match || out_ready);
    evt_done  = (state == MJ_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= MJ_COLLECT;
      hits  <= '0;
      seen  <= '0;
      idx   <= '0;
    end else begin
      for (int l = 0; l < LAYERS; l++) begin
        if (pop_o[l]) begin
          if (heads_i[l][ID_W]) seen[l] <= 1'b1;
          else                  hits[heads_i[l][ID_W-1:0]][l] <= 1'b1;
        end
      end
      case (state)
        MJ_COLLECT: begin
          if (&seen) begin
            state <= MJ_EMIT;
            idx   <= '0;
          end
        end
        MJ_EMIT: begin
          if (advance) begin
            hits[idx] <= '0;
            if (idx == ID_W'(NUM_PAT - 1)) state <= MJ_DONE;
            else                          idx   <= idx + ID_W'(1);
          end
        end
        default: begin
          seen  <= '0;
          state <= MJ_COLLECT;
        end
      endcase
    end
  end

endmodule

// File: rtl/pattern_vote_top.sv
module pattern_vote_top #(
  parameter int unsigned LAYERS     = 6,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned ID_W       = 5,
  parameter int unsigned NUM_PAT    = 32,
  parameter int unsigned MAX_FIRE   = 4,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned DEF_THR    = 5,
  localparam int unsigned THR_W     = $clog2(LAYERS + 1),
  localparam int unsigned CNT_W     = $clog2(MAX_FIRE + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     thr_wr,
  input  logic [THR_W-1:0]         thr_val,
  input  logic [LAYERS-1:0]        lane_valid,
  input  logic [LAYERS-1:0]        lane_eoe,
  input  logic [LAYERS*WORD_W-1:0] lane_word,
  output logic [LAYERS-1:0]        lane_ready,
  output logic [LAYERS-1:0]        lane_ovf,
  output logic                     hit_valid,
  input  logic                     hit_ready,
  output logic [ID_W-1:0]          hit_id,
  output logic                     evt_done
);

  logic [THR_W-1:0]              thr_q;
  logic [LAYERS*CNT_W-1:0]       fire_cnt_flat;
  logic [LAYERS-1:0]             fifo_empty;
  logic [LAYERS-1:0]             fifo_pop;
  logic [LAYERS-1:0][ID_W:0]     fifo_head;

  always_ff @(posedge clk) begin
    if (!rst_n)      thr_q <= THR_W'(DEF_THR);
    else if (thr_wr) thr_q <= thr_val;
  end

  for (genvar l = 0; l < LAYERS; l++) begin : g_lane
    logic [CNT_W-1:0]              cnt;
    logic [MAX_FIRE-1:0][ID_W-1:0] ids;

    pvm_comparator #(
      .LAYER(l), .WORD_W(WORD_W), .ID_W(ID_W),
      .NUM_PAT(NUM_PAT), .MAX_FIRE(MAX_FIRE)
    ) cmp_i (
      .word_i (lane_word[l*WORD_W +: WORD_W]),
      .cnt_o  (cnt),
      .ids_o  (ids)
    );

    assign fire_cnt_flat[l*CNT_W +: CNT_W] = cnt;

    pvm_layer_ingest #(
      .ID_W(ID_W), .DEPTH(FIFO_DEPTH), .MAX_FIRE(MAX_FIRE)
    ) ing_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (lane_valid[l]),
      .in_eoe   (lane_eoe[l]),
      .in_ready (lane_ready[l]),
      .fire_cnt (cnt),
      .fire_ids (ids),
      .pop_i    (fifo_pop[l]),
      .head_o   (fifo_head[l]),
      .empty_o  (fifo_empty[l]),
      .ovf_o    (lane_ovf[l])
    );
  end

  pvm_majority #(
    .LAYERS(LAYERS), .ID_W(ID_W), .NUM_PAT(NUM_PAT)
  ) vote_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .empty_i   (fifo_empty),
    .heads_i   (fifo_head),
    .pop_o     (fifo_pop),
    .thr_i     (thr_q),
    .out_valid (hit_valid),
    .out_ready (hit_ready),
    .out_id    (hit_id),
    .evt_done  (evt_done)
  );

endmodule

// File: rtl/pattern_vote_sva.sv
module pattern_vote_sva #(
  parameter int unsigned LAYERS = 6,
  parameter int unsigned ID_W   = 5,
  parameter int unsigned CNT_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LAYERS-1:0]       lane_valid,
  input logic [LAYERS-1:0]       lane_eoe,
  input logic [LAYERS-1:0]       lane_ready,
  input logic [LAYERS-1:0]       lane_ovf,
  input logic [LAYERS*CNT_W-1:0] fire_cnt,
  input logic                    hit_valid,
  input logic                    hit_ready,
  input logic [ID_W-1:0]         hit_id,
  input logic                    evt_done
);

  logic            have_last;
  logic [ID_W-1:0] last_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_id   <= '0;
    end else if (evt_done) begin
      have_last <= 1'b0;
    end else if (hit_valid && hit_ready) begin
      have_last <= 1'b1;
      last_id   <= hit_id;
    end
  end

  for (genvar l = 0; l < LAYERS; l++) begin : g_chk
    // R2: a firing word stalls its lane on the following cycle
    p_stall_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_valid[l] && lane_ready[l] && !lane_eoe[l] && fire_cnt[l*CNT_W +: CNT_W] != '0)
      |=> !lane_ready[l]);
    // R2: a marker stalls its lane for its push cycle
    p_stall_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_valid[l] && lane_ready[l] && lane_eoe[l]) |=> !lane_ready[l]);
    // R2: a silent word leaves the lane ready
    p_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_valid[l] && lane_ready[l] && !lane_eoe[l] && fire_cnt[l*CNT_W +: CNT_W] == '0)
      |=> lane_ready[l]);
    // R3: overflow flag is sticky
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lane_ovf[l] |=> lane_ovf[l]);
  end

  // R8: output holds under back-pressure
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_ready) |=> (hit_valid && $stable(hit_id)));

  // R5: done pulse never overlaps a valid output
  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> !hit_valid);

  // R5: outputs rise strictly within an event
  p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && have_last) |-> (hit_id > last_id));

endmodule

bind pattern_vote_top pattern_vote_sva #(
  .LAYERS(LAYERS), .ID_W(ID_W), .CNT_W(CNT_W)
) sva_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .lane_valid (lane_valid),
  .lane_eoe   (lane_eoe),
  .lane_ready (lane_ready),
  .lane_ovf   (lane_ovf),
  .fire_cnt   (fire_cnt_flat),
  .hit_valid  (hit_valid),
  .hit_ready  (hit_ready),
  .hit_id     (hit_id),
  .evt_done   (evt_done)
);

// File: tb/pattern_vote_top_tb_top.sv
`timescale 1ns/1ps
module pattern_vote_top_tb_top;

  localparam int L  = 6;
  localparam int WW = 16;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          thr_wr = 1'b0;
  logic [2:0]    thr_val = '0;
  logic [L-1:0]  lane_valid = '0;
  logic [L-1:0]  lane_eoe = '0;
  logic [L*WW-1:0] lane_word = '0;
  logic [L-1:0]  lane_ready;
  logic [L-1:0]  lane_ovf;
  logic          hit_valid;
  logic          hit_ready = 1'b0;
  logic [4:0]    hit_id;
  logic          evt_done;

  always #5 clk = ~clk;

  pattern_vote_top dut_i (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_val(thr_val),
    .lane_valid(lane_valid), .lane_eoe(lane_eoe), .lane_word(lane_word),
    .lane_ready(lane_ready), .lane_ovf(lane_ovf), .hit_valid(hit_valid),
    .hit_ready(hit_ready), .hit_id(hit_id), .evt_done(evt_done)
  );

  int checks = 0;
  int fails  = 0;
  bit exp_cur [NP][L];
  bit exp_nxt [NP][L];
  bit marker_sent [L];
  int cur_thr = 5;
  int got [$];
  int done_cnt = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Word that fires pattern p on layer l (R1 encoding)
  function automatic logic [15:0] key(input int l, input int p);
    return {4'(l), 7'b0, 5'(p >> (l % 3))};
  endfunction

  // Output consumer with a back-pressure pattern; records handshakes (R8)
  always @(negedge clk) begin
    logic rdy;
    cyc++;
    rdy = ((cyc % 5) != 2) && ((cyc % 7) != 4);
    hit_ready = rdy;
    if (rst_n && hit_valid && rdy) got.push_back(int'(hit_id));
    if (rst_n && evt_done) done_cnt++;
  end

  task automatic send_word(input int l, input logic [15:0] w, input bit drop_last);
    int s, b, c, n;
    s = l % 3;
    b = int'(w[4:0]);
    c = 0;
    if (w[15:12] == 4'(l) && w[11:5] == 7'd0 && b < (NP >> s)) c = 1 << s;
    for (int j = 0; j < c; j++) begin
      if (drop_last && j == c - 1) continue;
      if (marker_sent[l]) exp_nxt[b * (1 << s) + j][l] = 1'b1;
      else                exp_cur[b * (1 << s) + j][l] = 1'b1;
    end
    @(negedge clk);
    lane_valid[l] = 1'b1;
    lane_eoe[l]   = 1'b0;
    lane_word[l*WW +: WW] = w;
    while (!lane_ready[l]) @(negedge clk);
    @(negedge clk);
    lane_valid[l] = 1'b0;
    n = 0;
    while (!lane_ready[l] && n < 20) begin n++; @(negedge clk); end
    check(n == c, "R2 stall cycles after word", n, c);
  endtask

  task automatic send_marker(input int l);
    int n;
    @(negedge clk);
    lane_valid[l] = 1'b1;
    lane_eoe[l]   = 1'b1;
    while (!lane_ready[l]) @(negedge clk);
    @(negedge clk);
    lane_valid[l] = 1'b0;
    lane_eoe[l]   = 1'b0;
    n = 0;
    while (!lane_ready[l] && n < 20) begin n++; @(negedge clk); end
    check(n == 1, "R2 stall cycles after marker", n, 1);
    marker_sent[l] = 1'b1;
  endtask

  task automatic close_event(input string tag);
    int start, w, votes, k;
    int exp_list [$];
    bit ok;
    start = done_cnt;
    for (int l = 0; l < L; l++) if (!marker_sent[l]) send_marker(l);
    w = 0;
    while (done_cnt == start && w < 2000) begin w++; @(negedge clk); end
    check(done_cnt == start + 1, {tag, " R5 done pulse"}, done_cnt - start, 1);
    for (int p = 0; p < NP; p++) begin
      votes = 0;
      for (int l = 0; l < L; l++) votes += int'(exp_cur[p][l]);
      if (votes >= cur_thr) exp_list.push_back(p);
    end
    ok = (got.size() == exp_list.size());
    k = -1;
    if (ok) for (int i = 0; i < got.size(); i++) if (got[i] != exp_list[i] && k < 0) k = i;
    if (k >= 0) ok = 1'b0;
    if (!ok && got.size() == exp_list.size())
      check(1'b0, {tag, " R5 output id"}, got[k], exp_list[k]);
    else
      check(ok, {tag, " R5 output count"}, got.size(), exp_list.size());
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < L; l++) begin
        exp_cur[p][l] = exp_nxt[p][l];
        exp_nxt[p][l] = 1'b0;
      end
    for (int l = 0; l < L; l++) marker_sent[l] = 1'b0;
    got.delete();
  endtask

  task automatic set_thr(input int t);
    @(negedge clk);
    thr_wr = 1'b1;
    thr_val = 3'(t);
    @(negedge clk);
    thr_wr = 1'b0;
    cur_thr = t;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(lane_ready == '1, "R9 lane_ready after reset", int'(lane_ready), 63);
    check(!hit_valid && !evt_done, "R9 outputs idle after reset", int'({hit_valid, evt_done}), 0);
    check(lane_ovf == '0, "R9 overflow clear after reset", int'(lane_ovf), 0);

    // R1/R5/R7 sweep over every pattern, default threshold (R6)
    for (int p = 0; p < NP; p++) begin
      for (int l = 0; l < L; l++) begin
        bit skip;
        skip = ((p % 4) == 1 && l == (p % 6)) || ((p % 4) == 2 && l >= 4);
        if (!skip) send_word(l, key(l, p), 1'b0);
      end
      if ((p % 4) == 3) begin
        for (int l = 0; l < 3; l++) send_word(l, key(l, (p + 7) % NP), 1'b0);
        send_word(1, 16'hF003, 1'b0);              // R1 wrong layer tag
        send_word(2, {4'd2, 7'd1, 5'd0}, 1'b0);    // R1 nonzero pad
        send_word(5, {4'd5, 7'd0, 5'd9}, 1'b0);    // R1 base out of range
      end
      close_event("R1/R7 sweep");
    end

    // R4: repeated words in one layer count once
    for (int l = 0; l < 4; l++) begin
      send_word(l, key(l, 9), 1'b0);
      send_word(l, key(l, 9), 1'b0);
      for (int r = 0; r < 3; r++) send_word(l, key(l, 20), 1'b0);
    end
    send_word(4, key(4, 9), 1'b0);
    close_event("R4 duplicates");

    // R6: threshold programming
    set_thr(4);
    for (int l = 0; l < 4; l++) send_word(l, key(l, 12), 1'b0);
    close_event("R6 thr=4");
    set_thr(6);
    for (int l = 0; l < 6; l++) send_word(l, key(l, 26), 1'b0);
    for (int l = 0; l < 5; l++) send_word(l, key(l, 3), 1'b0);
    close_event("R6 thr=6");
    set_thr(5);

    // R10: lane words after its own marker belong to the next event
    send_marker(0);
    send_word(0, key(0, 17), 1'b0);
    for (int l = 1; l < 5; l++) send_word(l, key(l, 17), 1'b0);
    close_event("R10 early words");
    for (int l = 1; l < 5; l++) send_word(l, key(l, 17), 1'b0);
    close_event("R10 carried words");

    // R3: overflow drops an entry and latches
    check(lane_ovf == '0, "R3 no overflow before fill", int'(lane_ovf), 0);
    send_marker(0);
    for (int i = 0; i < 9; i++) send_word(0, key(0, i), i == 8);
    check(lane_ovf == 6'b000001, "R3 overflow flag on full lane", int'(lane_ovf), 1);
    close_event("R3 stalled event");
    for (int l = 1; l < 5; l++) begin
      send_word(l, key(l, 3), 1'b0);
      send_word(l, key(l, 8), 1'b0);
    end
    close_event("R3 dropped entry");
    check(lane_ovf == 6'b000001, "R3 overflow flag sticky", int'(lane_ovf), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule